// File: doc/BRIEF.md
# Interrupt Shadow Register Set

This block holds one hidden saved copy of three core registers: the status flags, the working register and the bank select register. The copy is taken from the live values whenever the processor enters an interrupt vector, of low or high priority, and whenever a call instruction is issued with its fast option. A return issued with the fast option hands the saved copy back. The block then raises a restore-enable for one cycle, and the register file loads the three restore values during that cycle.

There is exactly one saved copy and software has no path to read it or write it. Low-priority and high-priority entries both save into the same copy. A high-priority interrupt that arrives inside a low-priority handler therefore overwrites the low-priority save without any warning. Priority arbitration, instruction decode and the register file itself belong to other blocks.

Top module: `irq_shadow_set`

## Requirements
- R1: After reset, restoreEn is 0 and all restore outputs are 0. The saved copy is cleared to zero, so a fast return issued straight after reset delivers all-zero restore values.
- R2: A clock edge with vecLow high saves liveStatus, liveWork and liveBank into the saved copy.
- R3: A clock edge with vecHigh high saves the three live values into the same copy.
- R4: A clock edge with fastCall high saves the three live values into the same copy.
- R5: A clock edge with fastReturn high makes restoreEn 1 for the following cycle. In that cycle the restore outputs carry the saved copy as it stood before that edge.
- R6: In any cycle that does not follow a fastReturn edge, restoreEn is 0 and restoreStatus, restoreWork and restoreBank are all 0.
- R7: At an edge with no save strobe (vecLow, vecHigh and fastCall all low), the saved copy keeps its value, whatever the live inputs do.
- R8: The store is a single entry. Each save replaces the previous one, so after a low-priority save followed by a high-priority save, every later fast return delivers the high-priority values only.
- R9: When a save strobe and fastReturn occur at the same edge, the restore delivers the old copy and the new values are held from then on.
- R10: A fast return does not consume the copy. Back-to-back fast returns deliver the same values each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveStatus | input | STATUS_W | Live status flags |
| liveWork | input | WORK_W | Live working register |
| liveBank | input | BANK_W | Live bank select register |
| vecLow | input | 1 | Entering a low-priority interrupt vector |
| vecHigh | input | 1 | Entering a high-priority interrupt vector |
| fastCall | input | 1 | Call issued with the fast option |
| fastReturn | input | 1 | Return issued with the fast option |
| restoreStatus | output | STATUS_W | Status value to load back (0 when idle) |
| restoreWork | output | WORK_W | Working register value to load back (0 when idle) |
| restoreBank | output | BANK_W | Bank select value to load back (0 when idle) |
| restoreEn | output | 1 | One-cycle load strobe for the restore values |

## Verification
The bench runs a low-priority save, then a high-priority save, then two fast returns. A design that kept more than one entry, or that popped a stack, would bring the low-priority values back on the second return. A save and a fast return in the same cycle must restore the old copy; a design with a bypass would return the new live values instead. Fast returns straight after reset must give zeros. In between, the live inputs keep changing with no save strobe, which exposes a design that tracks the live values or leaves the restore data visible outside the enable pulse.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic capture;   // load saved copy from live values
    logic restore;   // latch saved copy for the restore pulse
  } shadowCtrl_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vecLow,
  input  logic        vecHigh,
  input  logic        fastCall,
  input  logic        fastReturn,
  output shadowCtrl_t ctrl,
  output logic        restoreEn
);

  // Any save source loads the one shared entry
  always_comb begin
    ctrl.capture = vecLow | vecHigh | fastCall;
    ctrl.restore = fastReturn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) restoreEn <= 1'b0;
    else       restoreEn <= fastReturn;
  end

  // R5: the restore pulse follows a fast return
  a_r5_pulse_after_return: assert property (@(posedge clk) disable iff (!rstN)
    fastReturn |=> restoreEn);

  // R6: no pulse without a fast return
  a_r6_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !fastReturn |=> !restoreEn);

endmodule

// File: rtl/shadow_dpath.sv
module shadow_dpath
  import shadow_pkg::*;
#(
  parameter int STATUS_W = 5,
  parameter int WORK_W   = 8,
  parameter int BANK_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  shadowCtrl_t         ctrl,
  input  logic                restoreEn,
  input  logic [STATUS_W-1:0] liveStatus,
  input  logic [WORK_W-1:0]   liveWork,
  input  logic [BANK_W-1:0]   liveBank,
  output logic [STATUS_W-1:0] restoreStatus,
  output logic [WORK_W-1:0]   restoreWork,
  output logic [BANK_W-1:0]   restoreBank
);

  localparam int TotalW = STATUS_W + WORK_W + BANK_W;

  logic [TotalW-1:0] liveAll;
  logic [TotalW-1:0] shadowQ;
  logic [TotalW-1:0] restoreHold;
  logic [TotalW-1:0] restoreOut;

  assign liveAll = {liveStatus, liveWork, liveBank};

  // Single saved entry, shared by every save source
  always_ff @(posedge clk) begin
    if (!rstN)             shadowQ <= '0;
    else if (ctrl.capture) shadowQ <= liveAll;
  end

  // Restore data sampled from the pre-edge entry, so a simultaneous save
  // does not bypass into the restore
  always_ff @(posedge clk) begin
    if (!rstN)             restoreHold <= '0;
    else if (ctrl.restore) restoreHold <= shadowQ;
  end

  assign restoreOut = restoreEn ? restoreHold : '0;
  assign {restoreStatus, restoreWork, restoreBank} = restoreOut;

  // R2/R3/R4: any save strobe loads the live values
  a_r2_capture_live: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> shadowQ == $past(liveAll));

  // R7: no save strobe, entry unchanged
  a_r7_hold_entry: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(shadowQ));

  // R9: restore carries the entry from before the edge
  a_r9_restore_old: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restore |=> restoreOut == $past(shadowQ));

  // R6: outputs quiet outside the pulse
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !restoreEn |-> restoreOut == '0);

endmodule

// File: rtl/irq_shadow_set.sv
module irq_shadow_set
  import shadow_pkg::*;
#(
  parameter int STATUS_W = 5,
  parameter int WORK_W   = 8,
  parameter int BANK_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] liveStatus,
  input  logic [WORK_W-1:0]   liveWork,
  input  logic [BANK_W-1:0]   liveBank,
  input  logic                vecLow,
  input  logic                vecHigh,
  input  logic                fastCall,
  input  logic                fastReturn,
  output logic [STATUS_W-1:0] restoreStatus,
  output logic [WORK_W-1:0]   restoreWork,
  output logic [BANK_W-1:0]   restoreBank,
  output logic                restoreEn
);

  shadowCtrl_t ctrl;

  shadow_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .vecLow     (vecLow),
    .vecHigh    (vecHigh),
    .fastCall   (fastCall),
    .fastReturn (fastReturn),
    .ctrl       (ctrl),
    .restoreEn  (restoreEn)
  );

  shadow_dpath #(
    .STATUS_W (STATUS_W),
    .WORK_W   (WORK_W),
    .BANK_W   (BANK_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .restoreEn     (restoreEn),
    .liveStatus    (liveStatus),
    .liveWork      (liveWork),
    .liveBank      (liveBank),
    .restoreStatus (restoreStatus),
    .restoreWork   (restoreWork),
    .restoreBank   (restoreBank)
  );

  // R1: the first cycle out of reset carries no pulse
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !restoreEn);

endmodule

// File: tb/irq_shadow_set_bench.sv
module irq_shadow_set_bench;

  localparam int SW = 5, WW = 8, BW = 4;
  localparam int TW = SW + WW + BW;
  localparam int NVEC = 12;

  // entry: {vecLow, vecHigh, fastCall, fastReturn, status, work, bank}
  localparam logic [TW+3:0] VECS [NVEC] = '{
    {4'b0001, 5'h00, 8'h00, 4'h0},   // return right after reset
    {4'b1000, 5'h11, 8'hA5, 4'h3},   // low vector save
    {4'b0000, 5'h1F, 8'hFF, 4'hF},   // live changes, no save
    {4'b0001, 5'h02, 8'h33, 4'h1},   // return: old save
    {4'b0100, 5'h0A, 8'h5C, 4'h9},   // high vector save
    {4'b0001, 5'h00, 8'h00, 4'h0},
    {4'b0010, 5'h15, 8'h81, 4'h6},   // fast call save
    {4'b0000, 5'h07, 8'h07, 4'h7},
    {4'b0001, 5'h07, 8'h07, 4'h7},
    {4'b0001, 5'h01, 8'h02, 4'h3},   // back-to-back return
    {4'b1001, 5'h13, 8'h4E, 4'hB},   // save with return together
    {4'b0001, 5'h00, 8'h00, 4'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SW-1:0] liveStatus = '0;
  logic [WW-1:0] liveWork = '0;
  logic [BW-1:0] liveBank = '0;
  logic vecLow = 0, vecHigh = 0, fastCall = 0, fastReturn = 0;
  logic [SW-1:0] restoreStatus;
  logic [WW-1:0] restoreWork;
  logic [BW-1:0] restoreBank;
  logic restoreEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_shadow_set #(.STATUS_W(SW), .WORK_W(WW), .BANK_W(BW)) u_irq_shadow_set (
    .clk(clk), .rstN(rstN),
    .liveStatus(liveStatus), .liveWork(liveWork), .liveBank(liveBank),
    .vecLow(vecLow), .vecHigh(vecHigh), .fastCall(fastCall), .fastReturn(fastReturn),
    .restoreStatus(restoreStatus), .restoreWork(restoreWork),
    .restoreBank(restoreBank), .restoreEn(restoreEn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(logic [3:0] strb, logic [TW-1:0] live);
    @(negedge clk);
    {vecLow, vecHigh, fastCall, fastReturn} = strb;
    {liveStatus, liveWork, liveBank} = live;
    @(posedge clk);
    #1;
  endtask

  task automatic chkOut(string req, logic en, logic [TW-1:0] data);
    chk({req, " enable"}, 32'(restoreEn), 32'(en));
    chk({req, " data"}, 32'({restoreStatus, restoreWork, restoreBank}), 32'(data));
  endtask

  localparam logic [TW-1:0] VAL_A = {5'h0C, 8'h12, 4'h5};
  localparam logic [TW-1:0] VAL_B = {5'h19, 8'hE7, 4'hA};
  localparam logic [TW-1:0] VAL_C = {5'h03, 8'h6D, 4'h2};

  initial begin
    logic [TW-1:0] model;
    logic [TW-1:0] expData;
    logic expEn;

    repeat (3) @(posedge clk);
    #1;
    chkOut("R1 in reset", 1'b0, '0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk against a behavioural model of the requirements
    model = '0;
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] strb;
      logic [TW-1:0] live;
      {strb, live} = VECS[i];
      expEn = strb[0];                       // R5 / R6
      expData = strb[0] ? model : '0;        // R9: old entry
      if (strb[3] | strb[2] | strb[1]) model = live;  // R2 R3 R4 R8
      step(strb, live);
      chkOut($sformatf("R5 R6 R7 R10 vector %0d", i), expEn, expData);
    end

    // directed: reset again, return gives zeros
    @(negedge clk);
    rstN = 1'b0;
    step(4'b0000, '0);
    @(negedge clk);
    rstN = 1'b1;
    step(4'b0001, VAL_C);
    chkOut("R1 zero after reset", 1'b1, '0);

    // nested low then high: the low save is lost (R8)
    step(4'b1000, VAL_A);
    chkOut("R2 low save quiet", 1'b0, '0);
    step(4'b0100, VAL_B);
    chkOut("R3 high save quiet", 1'b0, '0);
    step(4'b0001, VAL_C);
    chkOut("R8 high return", 1'b1, VAL_B);
    step(4'b0001, VAL_A);
    chkOut("R8 low values lost", 1'b1, VAL_B);
    step(4'b0000, VAL_A);
    chkOut("R6 idle after returns", 1'b0, '0);

    // simultaneous save and return (R9)
    step(4'b0011, VAL_C);
    chkOut("R9 old copy restored", 1'b1, VAL_B);
    step(4'b0001, VAL_A);
    chkOut("R9 new copy held", 1'b1, VAL_C);

    // live churn without save strobes (R7)
    step(4'b0000, VAL_A);
    step(4'b0000, VAL_B);
    step(4'b0001, VAL_A);
    chkOut("R7 entry held", 1'b1, VAL_C);

    // fast call save (R4)
    step(4'b0010, VAL_A);
    step(4'b0001, VAL_B);
    chkOut("R4 call save", 1'b1, VAL_A);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule